// File: doc/BRIEF.md
# Cell Receive Status and Interrupt Register

This block holds one status byte for each port of a cell-based receive interface and combines the ports' events into a single interrupt line. For each port it keeps two sticky event flags. One records a receive FIFO overrun. The other records any change in the loss-of-cell-delineation (LCD) condition. Each flag has its own enable mask. Next to these flags the byte shows live conditions: the LCD level, the header-error receiver mode and the cell delineation state.

The delineation state machine, the FIFO and the header check logic sit outside this block and deliver their status as inputs. A host reads a port by giving a port select together with a one-cycle read strobe. The byte comes back on the next cycle. The same read clears that port's event flags. One registered interrupt output stays high while any event flag is set on any port.

Top module: `cell_rx_status`

## Requirements
- R1: The status byte is laid out as: bit 0 overrun event, bit 1 LCD change event, bit 2 live LCD, bit 3 receiver mode, bits 5:4 delineation state. Bits 7:6 always read 0.
- R2: A FIFO overrun pulse sets a port's bit 0 only if that port's overrun mask is 1 in the same cycle. With the mask at 0 the pulse leaves bit 0 at 0.
- R3: A change of a port's LCD input, either 0 to 1 or 1 to 0, sets bit 1 only if that port's LCD mask is 1. With the mask at 0 the change leaves bit 1 at 0.
- R4: Bit 2 shows the port's current LCD input, one register stage late. It is 0 while cells are delineated and 1 on loss of delineation.
- R5: Bit 3 is 1 for detection mode and 0 for correction mode. It reads 0 whenever header error correction is disabled for that port.
- R6: Bits 5:4 carry the delineation code: 00 for HUNT, 01 for PRESYNC, 1x for SYNC.
- R7: A read clears bits 1:0 of the selected port only. Other ports keep their event bits.
- R8: The interrupt output is 1 in the cycle after any event bit of any port is set. It returns to 0 in the cycle after every event bit of every port is 0.
- R9: After reset the read data, the interrupt and every status bit are 0.
- R10: An event that arrives in the same cycle as a clearing read stays set after that read.
- R11: The read data is updated one cycle after the strobe and holds the byte as it was before the clear. It keeps that value while no strobe is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_ovr | input | NUM_PORTS | Overrun pulse, one bit per port |
| ovr_mask | input | NUM_PORTS | Overrun event enable, one bit per port |
| lcd_in | input | NUM_PORTS | Loss-of-cell-delineation level, one bit per port |
| lcd_mask | input | NUM_PORTS | LCD change event enable, one bit per port |
| hec_en | input | NUM_PORTS | Header error correction enabled, one bit per port |
| det_mode | input | NUM_PORTS | Receiver in detection mode, one bit per port |
| delin_st | input | 2*NUM_PORTS | Delineation state code, two bits per port |
| rd_stb | input | 1 | One-cycle read strobe |
| rd_sel | input | SEL_W | Port to read |
| rd_data | output | 8 | Status byte from the last read |
| irq | output | 1 | Combined interrupt of all ports |

## Verification
The assertions assume that the port select is in range whenever the strobe is high. They also assume that the overrun input is a pulse sampled on each clock edge, with the masks held at their level for the cycle in which they apply. The stimulus changes all inputs only on the falling edge. It selects only existing ports. It opens the masks only after the LCD inputs have settled, so leftover level changes from earlier steps cannot raise events by accident.

// File: rtl/cell_rx_status.sv
module cell_rx_status #(
  parameter int NUM_PORTS = 4,
  localparam int SEL_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_PORTS-1:0]   fifo_ovr,
  input  logic [NUM_PORTS-1:0]   ovr_mask,
  input  logic [NUM_PORTS-1:0]   lcd_in,
  input  logic [NUM_PORTS-1:0]   lcd_mask,
  input  logic [NUM_PORTS-1:0]   hec_en,
  input  logic [NUM_PORTS-1:0]   det_mode,
  input  logic [2*NUM_PORTS-1:0] delin_st,
  input  logic                   rd_stb,
  input  logic [SEL_W-1:0]       rd_sel,
  output logic [7:0]             rd_data,
  output logic                   irq
);

  logic [NUM_PORTS-1:0]   lcd_q, lcd_prev, mode_q, ovr_evt, lcd_evt, rd_hit;
  logic [2*NUM_PORTS-1:0] st_q;
  logic [7:0]             byte_of [NUM_PORTS];

  wire [NUM_PORTS-1:0] lcd_chg = lcd_q ^ lcd_prev;

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      rd_hit[p]  = rd_stb && (rd_sel == SEL_W'(p));
      byte_of[p] = {2'b00, st_q[2*p+1 -: 2], mode_q[p], lcd_q[p], lcd_evt[p], ovr_evt[p]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcd_q    <= '0;
      lcd_prev <= '0;
      mode_q   <= '0;
      st_q     <= '0;
      ovr_evt  <= '0;
      lcd_evt  <= '0;
      irq      <= 1'b0;
      rd_data  <= '0;
    end else begin
      lcd_q    <= lcd_in;
      lcd_prev <= lcd_q;
      mode_q   <= hec_en & det_mode;
      st_q     <= delin_st;
      ovr_evt  <= (ovr_evt & ~rd_hit) | (fifo_ovr & ovr_mask);
      lcd_evt  <= (lcd_evt & ~rd_hit) | (lcd_chg & lcd_mask);
      irq      <= |{ovr_evt, lcd_evt};
      if (rd_stb)
        rd_data <= (int'(rd_sel) < NUM_PORTS) ? byte_of[rd_sel] : 8'h00;
    end
  end

endmodule

// File: rtl/cell_rx_status_chk.sv
module cell_rx_status_chk #(
  parameter int NUM_PORTS = 4,
  parameter int SEL_W = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_PORTS-1:0] fifo_ovr,
  input logic [NUM_PORTS-1:0] ovr_mask,
  input logic                 rd_stb,
  input logic [SEL_W-1:0]     rd_sel,
  input logic [7:0]           rd_data,
  input logic                 irq,
  input logic [NUM_PORTS-1:0] ovr_evt,
  input logic [NUM_PORTS-1:0] lcd_evt
);

  a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (|{ovr_evt, lcd_evt}) |=> irq);

  a_r8_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !(|{ovr_evt, lcd_evt}) |=> !irq);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));

  a_r1_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> (rd_data[7:6] == 2'b00));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    a_r2_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_ovr[p] && ovr_mask[p]) |=> ovr_evt[p]);

    a_r2_ovr_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_evt[p] && !(fifo_ovr[p] && ovr_mask[p])) |=> !ovr_evt[p]);

    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && rd_sel == SEL_W'(p) && !(fifo_ovr[p] && ovr_mask[p])) |=> !ovr_evt[p]);
  end

endmodule

bind cell_rx_status cell_rx_status_chk #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .fifo_ovr(fifo_ovr), .ovr_mask(ovr_mask),
  .rd_stb(rd_stb), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq),
  .ovr_evt(ovr_evt), .lcd_evt(lcd_evt)
);

// File: tb/cell_rx_status_tb_top.sv
module cell_rx_status_tb_top;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] fifo_ovr = '0, ovr_mask = '0, lcd_in = '0, lcd_mask = '0;
  logic [N-1:0] hec_en = '0, det_mode = '0;
  logic [2*N-1:0] delin_st = '0;
  logic rd_stb = 1'b0;
  logic [1:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic irq;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cell_rx_status #(.NUM_PORTS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_ovr(fifo_ovr), .ovr_mask(ovr_mask),
    .lcd_in(lcd_in), .lcd_mask(lcd_mask), .hec_en(hec_en), .det_mode(det_mode),
    .delin_st(delin_st), .rd_stb(rd_stb), .rd_sel(rd_sel),
    .rd_data(rd_data), .irq(irq)
  );

  // {port[15:14], lcd[13], hec[12], det[11], state[10:9], pad[8], expected[7:0]}
  localparam logic [15:0] VEC [6] = '{
    {2'd0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 8'h00},
    {2'd1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 8'h04},
    {2'd2, 1'b0, 1'b1, 1'b1, 2'b01, 1'b0, 8'h18},
    {2'd3, 1'b0, 1'b0, 1'b1, 2'b10, 1'b0, 8'h20},
    {2'd0, 1'b1, 1'b1, 1'b0, 2'b11, 1'b0, 8'h34},
    {2'd1, 1'b1, 1'b1, 1'b1, 2'b10, 1'b0, 8'h2C}
  };

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic do_read(input int p, output logic [7:0] d);
    rd_sel = 2'(p);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    idle(2);
    check8("R9 reset data", rd_data, 8'h00);
    check1("R9 reset irq", irq, 1'b0);
    rst_n = 1'b1;
    idle(2);

    // R1 R4 R5 R6 live status walk, masks closed
    for (int i = 0; i < 6; i++) begin
      int p;
      p = int'(VEC[i][15:14]);
      lcd_in[p] = VEC[i][13];
      hec_en[p] = VEC[i][12];
      det_mode[p] = VEC[i][11];
      delin_st[2*p +: 2] = VEC[i][10:9];
      idle(2);
      do_read(p, d);
      check8("R1/R4/R5/R6 live byte", d, VEC[i][7:0]);
      check1("R3 no event with mask closed", irq, 1'b0);
    end

    lcd_in = '0; hec_en = '0; det_mode = '0; delin_st = '0;
    idle(3);
    for (int p = 0; p < N; p++) begin
      do_read(p, d);
      check8("R9 clean port", d, 8'h00);
    end

    // R2 masked overrun
    fifo_ovr[1] = 1'b1;
    idle(1);
    fifo_ovr[1] = 1'b0;
    idle(1);
    check1("R2 masked no irq", irq, 1'b0);
    do_read(1, d);
    check8("R2 masked overrun", d, 8'h00);

    // R2 R8 enabled overrun, R7 clear
    ovr_mask = '1;
    fifo_ovr[1] = 1'b1;
    idle(1);
    fifo_ovr[1] = 1'b0;
    idle(1);
    check1("R8 irq raised", irq, 1'b1);
    do_read(2, d);
    check8("R7 other port untouched", d, 8'h00);
    do_read(1, d);
    check8("R2 overrun latched", d, 8'h01);
    idle(1);
    check1("R8 irq dropped", irq, 1'b0);
    do_read(1, d);
    check8("R7 cleared by read", d, 8'h00);

    // R11 hold without strobe
    idle(3);
    check8("R11 data held", rd_data, 8'h00);

    // R3 LCD change both directions
    lcd_mask[2] = 1'b1;
    lcd_in[2] = 1'b1;
    idle(2);
    do_read(2, d);
    check8("R3 rise event", d, 8'h06);
    do_read(2, d);
    check8("R3 rise cleared, R4 level", d, 8'h04);
    lcd_in[2] = 1'b0;
    idle(2);
    do_read(2, d);
    check8("R3 fall event", d, 8'h02);
    lcd_mask[2] = 1'b0;
    lcd_in[2] = 1'b1;
    idle(2);
    do_read(2, d);
    check8("R3 masked change", d, 8'h04);
    lcd_in[2] = 1'b0;
    idle(3);

    // R10 event in the same cycle as the clearing read
    fifo_ovr[0] = 1'b1;
    rd_sel = 2'd0;
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    fifo_ovr[0] = 1'b0;
    check8("R11 pre-clear capture", rd_data, 8'h00);
    idle(1);
    check1("R10 irq held", irq, 1'b1);
    do_read(0, d);
    check8("R10 event kept", d, 8'h01);

    // R8 several ports
    fifo_ovr[0] = 1'b1;
    fifo_ovr[3] = 1'b1;
    idle(1);
    fifo_ovr = '0;
    do_read(0, d);
    check8("R7 port 0 read", d, 8'h01);
    idle(1);
    check1("R8 irq kept by port 3", irq, 1'b1);
    do_read(3, d);
    check8("R7 port 3 read", d, 8'h01);
    idle(1);
    check1("R8 irq released", irq, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule